// File: doc/BRIEF.md
# External Interrupt Line Controller

This block collects a small set of external interrupt lines and turns them into a single prioritised request toward a processor core. Each line has its own two-bit sense mode. In the three edge modes, a detected transition sets a pending flag. That flag is latched regardless of the line's enable bit and regardless of the global enable. A line that was masked when its event arrived therefore fires as soon as software unmasks it. In the low-level mode no flag is kept, and the request follows the pin for as long as the pin stays low.

Software programs the block through three write strobes, one for the mode fields, one for the enable mask and one for write-one-to-clear of the flags. It controls the global enable through set and clear pulses. The core accepts a request with a valid/ready handshake and later signals return-from-interrupt.

The request channel is not a buffered stream. Its rules are as follows:
- `irq_valid` and `irq_vec` are computed in the same cycle from the current flags, pins, mask and global enable.
- Either can change, or valid can drop, before the handshake completes: when a higher-priority line becomes eligible, a level pin is released, or a line is masked.
- A transfer happens only in a cycle where both valid and ready are high.
- Ready has no effect while valid is low.

Inputs are assumed to be already synchronised to `clk`.

Top module: `xint_ctrl`

## Requirements
- R1: Mode field of line i is bits [2i+1:2i] of the mode register, with 00 = low level, 01 = any edge, 10 = falling edge and 11 = rising edge. In an edge mode, the selected transition sets the line's pending flag whether or not the line's enable bit is set.
- R2: A flag latched while its line was masked raises `irq_valid` with that line's vector from the cycle after the enable bit is written to 1, provided the global enable is set.
- R3: In low-level mode no flag is latched. While the line is enabled and the global enable is set, `irq_valid` follows the pin in the same cycle: asserted while the pin is 0, dropped once it is 1. A low level seen while masked leaves nothing behind.
- R4: Flags latch while the global enable is clear, and no request is raised until the global enable is set again.
- R5: Writing 1 to a flag bit clears it, and a cleared event produces no request on a later unmask. If an edge arrives in the same cycle as the clear, the flag stays set.
- R6: When several enabled lines are eligible, `irq_vec` gives the lowest-numbered one.
- R7: When `irq_valid` and `irq_ready` are both high, the global enable is cleared and the pending flag of the vectored line is cleared. Both take effect from the next cycle.
- R8: A `reti` pulse sets the global enable. A `gie_set` pulse does the same. A clear (acceptance or `gie_clr`) in the same cycle wins.
- R9: Each edge is detected against the previous cycle's pin value, so one transition sets the flag once, and a pin held steady raises no further request after service.
- R10: After reset, all modes are 00, the mask and flags are 0 and the global enable is clear, so `irq_valid` is 0. `irq_ready` has no effect while `irq_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | N_LINES | Synchronised interrupt pins |
| mode_we | input | 1 | Write strobe for the mode fields |
| mode_wdata | input | 2*N_LINES | New mode fields, two bits per line |
| mask_we | input | 1 | Write strobe for the enable mask |
| mask_wdata | input | N_LINES | New enable mask |
| clr_we | input | 1 | Write strobe for flag clearing |
| clr_wdata | input | N_LINES | Write 1 to clear the matching flag |
| gie_set | input | 1 | Set the global enable |
| gie_clr | input | 1 | Clear the global enable |
| reti | input | 1 | Return-from-interrupt event |
| irq_valid | output | 1 | Interrupt request |
| irq_vec | output | VEC_W | Index of the requesting line |
| irq_ready | input | 1 | Core accepts the request |

## Verification
The hardest situations to reach are the collisions: an edge landing in exactly the cycle its flag is being cleared, and a higher-priority level line overtaking a pending edge request before the core accepts it. The stimulus drives the pin transition and the clear strobe in the same cycle. It also raises a low-level line while a lower-priority edge request is held unacknowledged, then releases it. A behavioural model tracks flags, mask and enable on every clock, so any divergence in vector or valid is caught in the cycle it occurs.

// File: rtl/xint_pkg.sv
package xint_pkg;
  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;
endpackage

// File: rtl/xint_sense.sv
module xint_sense #(
  parameter int N_LINES = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_LINES-1:0]     pin_i,
  input  logic [2*N_LINES-1:0]   mode_i,
  output logic [N_LINES-1:0]     hit_o,
  output logic [N_LINES-1:0]     lvl_mode_o,
  output logic [N_LINES-1:0]     lvl_act_o
);
  import xint_pkg::*;

  logic [N_LINES-1:0] pin_q;
  logic               seen_q;

  // previous-cycle pin values; seen_q blocks a false edge right after reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q  <= '1;
      seen_q <= 1'b0;
    end else begin
      pin_q  <= pin_i;
      seen_q <= 1'b1;
    end
  end

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    sense_e md;
    assign md = sense_e'(mode_i[2*i+1:2*i]);
    always_comb begin
      unique case (md)
        SENSE_ANY:  hit_o[i] = seen_q & (pin_i[i] ^ pin_q[i]);
        SENSE_FALL: hit_o[i] = seen_q & ~pin_i[i] & pin_q[i];
        SENSE_RISE: hit_o[i] = seen_q & pin_i[i] & ~pin_q[i];
        default:    hit_o[i] = 1'b0;
      endcase
    end
    assign lvl_mode_o[i] = (md == SENSE_LOW);
    assign lvl_act_o[i]  = (md == SENSE_LOW) & ~pin_i[i];

    // R9: a steady pin produces no edge
    a_r9_steady_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_q && pin_i[i] == pin_q[i]) |-> !hit_o[i]);
  end
endmodule

// File: rtl/xint_arb.sv
module xint_arb #(
  parameter int N_LINES = 4,
  parameter int VEC_W   = 2
) (
  input  logic [N_LINES-1:0] req_i,
  output logic [N_LINES-1:0] grant_o,
  output logic [VEC_W-1:0]   vec_o,
  output logic               any_o
);
  // lowest index wins: scan downward so the last match is the lowest
  always_comb begin
    grant_o = '0;
    vec_o   = '0;
    for (int i = N_LINES - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        grant_o    = '0;
        grant_o[i] = 1'b1;
        vec_o      = VEC_W'(i);
      end
    end
    any_o = |req_i;
  end

  // R6: a single winner at most
  always_comb begin
    a_r6_single_grant: assert ($onehot0(grant_o));
  end
endmodule

// File: rtl/xint_ctrl.sv
module xint_ctrl #(
  parameter int N_LINES = 4,
  localparam int VEC_W  = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_LINES-1:0]   pin_i,
  input  logic                 mode_we,
  input  logic [2*N_LINES-1:0] mode_wdata,
  input  logic                 mask_we,
  input  logic [N_LINES-1:0]   mask_wdata,
  input  logic                 clr_we,
  input  logic [N_LINES-1:0]   clr_wdata,
  input  logic                 gie_set,
  input  logic                 gie_clr,
  input  logic                 reti,
  output logic                 irq_valid,
  output logic [VEC_W-1:0]     irq_vec,
  input  logic                 irq_ready
);
  logic [2*N_LINES-1:0] mode_q;
  logic [N_LINES-1:0]   mask_q, flag_q, flag_d;
  logic                 gie_q;
  logic [N_LINES-1:0]   hit, lvl_mode, lvl_act, elig, grant, clr_bits, ack_bits;
  logic                 any, ack;

  xint_sense #(.N_LINES(N_LINES)) u_sense (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .mode_i(mode_q),
    .hit_o(hit), .lvl_mode_o(lvl_mode), .lvl_act_o(lvl_act)
  );

  assign elig = mask_q & ((flag_q & ~lvl_mode) | lvl_act);

  xint_arb #(.N_LINES(N_LINES), .VEC_W(VEC_W)) u_arb (
    .req_i(elig), .grant_o(grant), .vec_o(irq_vec), .any_o(any)
  );

  assign irq_valid = gie_q & any;
  assign ack       = irq_valid & irq_ready;
  assign ack_bits  = ack ? grant : '0;
  assign clr_bits  = clr_we ? clr_wdata : '0;
  // new edge wins over clear and acceptance; level lines hold no flag
  assign flag_d    = ~lvl_mode & ((flag_q & ~clr_bits & ~ack_bits) | hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      mask_q <= '0;
      flag_q <= '0;
      gie_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      if (mode_we) mode_q <= mode_wdata;
      if (mask_we) mask_q <= mask_wdata;
      if (ack || gie_clr)      gie_q <= 1'b0;
      else if (gie_set || reti) gie_q <= 1'b1;
    end
  end

  for (genvar i = 0; i < N_LINES; i++) begin : g_chk
    // R1: an edge latches the flag, mask notwithstanding
    a_r1_edge_latch: assert property (@(posedge clk) disable iff (!rst_n)
      hit[i] |=> flag_q[i]);
    // R3: no flag survives in level mode
    a_r3_level_noflag: assert property (@(posedge clk) disable iff (!rst_n)
      lvl_mode[i] |=> !flag_q[i]);
    // R5: write-one clears when no edge collides
    a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && clr_wdata[i] && !hit[i]) |=> !flag_q[i]);
  end

  // R7: acceptance drops the global enable
  a_r7_ack_gie: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !gie_q);
  // R8: return restores the global enable
  a_r8_reti_gie: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !ack && !gie_clr) |=> gie_q);
endmodule

// File: tb/sim_xint_ctrl.sv
module sim_xint_ctrl;
  localparam int N = 4;
  localparam int VW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] pin = '1;
  logic mode_we = 0, mask_we = 0, clr_we = 0, gie_set = 0, gie_clr = 0, reti = 0, rdy = 0;
  logic [2*N-1:0] mode_wd = '0;
  logic [N-1:0] mask_wd = '0, clr_wd = '0;
  logic irq_valid;
  logic [VW-1:0] irq_vec;

  int checks = 0, errors = 0;
  bit done = 0;
  string tag = "R10";

  // reference model state
  int mmode[N];
  bit mflag[N];
  bit mmask[N];
  bit mprev[N];
  bit mgie, mseen;

  always #5 clk = ~clk;

  xint_ctrl #(.N_LINES(N)) u0 (
    .clk(clk), .rst_n(rst_n), .pin_i(pin),
    .mode_we(mode_we), .mode_wdata(mode_wd),
    .mask_we(mask_we), .mask_wdata(mask_wd),
    .clr_we(clr_we), .clr_wdata(clr_wd),
    .gie_set(gie_set), .gie_clr(gie_clr), .reti(reti),
    .irq_valid(irq_valid), .irq_vec(irq_vec), .irq_ready(rdy)
  );

  function automatic bit m_elig(int i);
    if (!mmask[i]) return 0;
    if (mmode[i] == 0) return pin[i] == 1'b0;
    return mflag[i];
  endfunction

  function automatic bit m_valid();
    bit a = 0;
    for (int i = 0; i < N; i++) if (m_elig(i)) a = 1;
    return mgie && a;
  endfunction

  function automatic int m_vec();
    for (int i = 0; i < N; i++) if (m_elig(i)) return i;
    return 0;
  endfunction

  task automatic m_reset();
    for (int i = 0; i < N; i++) begin
      mmode[i] = 0; mflag[i] = 0; mmask[i] = 0; mprev[i] = 1;
    end
    mgie = 0; mseen = 0;
  endtask

  task automatic m_clock();
    bit acc;
    int v;
    acc = m_valid() && rdy;
    v = m_vec();
    for (int i = 0; i < N; i++) begin
      bit h;
      bit p;
      p = pin[i];
      h = 0;
      if (mseen) begin
        if (mmode[i] == 1) h = (p != mprev[i]);
        if (mmode[i] == 2) h = (!p && mprev[i]);
        if (mmode[i] == 3) h = (p && !mprev[i]);
      end
      if (mmode[i] == 0) mflag[i] = 0;
      else begin
        if (clr_we && clr_wd[i]) mflag[i] = 0;
        if (acc && v == i) mflag[i] = 0;
        if (h) mflag[i] = 1;
      end
      mprev[i] = p;
    end
    for (int i = 0; i < N; i++) begin
      if (mode_we) mmode[i] = int'(mode_wd[2*i +: 2]);
      if (mask_we) mmask[i] = mask_wd[i];
    end
    if (acc || gie_clr) mgie = 0;
    else if (gie_set || reti) mgie = 1;
    mseen = 1;
  endtask

  task automatic compare();
    bit ev;
    int ec;
    ev = m_valid();
    ec = m_vec();
    checks++;
    if (irq_valid !== ev || (ev && int'(irq_vec) != ec)) begin
      errors++;
      $display("FAIL %s: valid=%0b vec=%0d expected valid=%0b vec=%0d",
               tag, irq_valid, irq_vec, ev, ec);
    end
  endtask

  task automatic expect_req(bit v, int vec);
    checks++;
    if (irq_valid !== v || (v && int'(irq_vec) != vec)) begin
      errors++;
      $display("FAIL %s: valid=%0b vec=%0d expected valid=%0b vec=%0d",
               tag, irq_valid, irq_vec, v, vec);
    end
  endtask

  task automatic cyc(int n = 1);
    for (int k = 0; k < n; k++) begin
      #1;
      compare();
      @(posedge clk);
      m_clock();
      @(negedge clk);
      mode_we = 0; mask_we = 0; clr_we = 0;
      gie_set = 0; gie_clr = 0; reti = 0; rdy = 0;
    end
  endtask

  task automatic serve();
    rdy = 1; cyc();
    reti = 1; cyc();
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: ran=1 expected ran=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    m_reset();
    repeat (3) @(negedge clk);
    tag = "R10"; expect_req(0, 0);
    rst_n = 1;
    cyc(2);
    expect_req(0, 0);

    // R1: falling edge on masked line 0 latches silently
    tag = "R1";
    mode_we = 1; mode_wd = 8'b10101110; gie_set = 1; cyc(2);
    pin[0] = 0; cyc(2);
    expect_req(0, 0);
    pin[0] = 1; cyc();

    // R2: unmask fires the remembered event
    tag = "R2";
    mask_we = 1; mask_wd = 4'b0001; cyc();
    expect_req(1, 0);

    // R7: acceptance clears enable and flag
    tag = "R7";
    rdy = 1; cyc();
    expect_req(0, 0);
    cyc();

    // R8: return re-enables, flag already gone
    tag = "R8";
    reti = 1; cyc(2);
    expect_req(0, 0);
    pin[0] = 0; cyc();
    expect_req(1, 0);
    serve(); pin[0] = 1; cyc();

    // R5: write-one clear, collision with edge, discard before unmask
    tag = "R5";
    mask_we = 1; mask_wd = 4'b0011; cyc();
    pin[1] = 0; cyc(); pin[1] = 1; cyc();
    expect_req(1, 1);
    clr_we = 1; clr_wd = 4'b0010; cyc();
    expect_req(0, 0);
    pin[1] = 0; cyc();
    pin[1] = 1; clr_we = 1; clr_wd = 4'b0010; cyc();
    expect_req(1, 1);
    clr_we = 1; clr_wd = 4'b0010; cyc();
    pin[2] = 0; cyc();
    clr_we = 1; clr_wd = 4'b0100; cyc();
    mask_we = 1; mask_wd = 4'b0111; cyc();
    expect_req(0, 0);
    pin[2] = 1; cyc();

    // R6: simultaneous lines 2 and 3, lower index first
    tag = "R6";
    mask_we = 1; mask_wd = 4'b1111; cyc();
    pin[2] = 0; pin[3] = 0; cyc();
    expect_req(1, 2);
    serve();
    expect_req(1, 3);
    serve();
    pin[2] = 1; pin[3] = 1; cyc(2);

    // R4: latched while global enable clear
    tag = "R4";
    gie_clr = 1; cyc();
    pin[0] = 0; cyc(3);
    expect_req(0, 0);
    gie_set = 1; cyc();
    expect_req(1, 0);
    serve(); pin[0] = 1; cyc();

    // R9: any-edge, held pin gives one event only
    tag = "R9";
    mode_we = 1; mode_wd = 8'b10100110; cyc();
    pin[1] = 0; cyc();
    expect_req(1, 1);
    serve(); cyc(3);
    expect_req(0, 0);
    pin[1] = 1; cyc();
    expect_req(1, 1);
    serve(); cyc();

    // R3: low-level line 0 follows the pin, leaves no flag
    tag = "R3";
    mode_we = 1; mode_wd = 8'b10100100; cyc();
    pin[0] = 0; #1; expect_req(1, 0);
    cyc(2);
    pin[0] = 1; #1; expect_req(0, 0);
    cyc();
    mask_we = 1; mask_wd = 4'b1110; cyc();
    pin[0] = 0; cyc(3);
    pin[0] = 1; cyc();
    mask_we = 1; mask_wd = 4'b1111; cyc();
    expect_req(0, 0);
    pin[0] = 0; cyc(); serve(); pin[0] = 1; cyc();

    // R10: ready ignored while idle; vector tracks a higher priority line
    tag = "R10";
    rdy = 1; cyc(); rdy = 1; cyc();
    pin[2] = 0; cyc();
    expect_req(1, 2);
    pin[0] = 0; #1; expect_req(1, 0);
    cyc();
    pin[0] = 1; #1; expect_req(1, 2);
    cyc();
    serve(); pin[2] = 1; cyc(2);
    expect_req(0, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule